// File: doc/BRIEF.md
# Programmable Horizontal Sync Generator

This block watches an 8-bit multiplexed 4:2:2 byte stream, one byte per clock of the line-locked clock. It finds the end-of-active-video timing code in that stream and clears a horizontal position counter on it. A horizontal sync pulse is then placed against that counter. Two 11-bit offsets set where the pulse starts and where it stops, and one bit sets its polarity. The offsets are written through a small byte-wide register port.

The stream detector is a four-state machine. `S_IDLE` waits for a sync byte. `S_FF` means an all-ones byte was seen. `S_Z1` means one zero byte followed it, and `S_Z2` means two zero bytes followed it. Its transitions are as follows:
- An all-ones byte moves any state to `S_FF`, and this includes an all-ones code byte seen in `S_Z2`.
- A zero byte moves `S_FF` to `S_Z1`, and a zero byte moves `S_Z1` to `S_Z2`.
- Every other byte returns the machine to `S_IDLE`.
- In `S_Z2`, the incoming byte is the code byte. When its bit 4 is 1, the detector raises a one-cycle end-of-active-video hit.

The timer has two states. `T_UNLOCKED` holds the output inactive until the first hit arrives. `T_RUN` counts. Every hit, from either state, moves the timer to `T_RUN` and clears the counter.

Written settings first go to staging registers. They are copied into the working set on the same clock edge that clears the counter. A line that is already under way therefore always finishes with the settings it started with.

Top module: `hsync_gen`

## Requirements
- R1: The counter clears on a sync byte 0xFF, then 0x00, then 0x00, followed by a code byte with bit 4 = 1. Count 0 is the clock cycle right after the code byte.
- R2: A code byte with bit 4 = 0 after the same prefix leaves the counter running.
- R3: Only the exact prefix counts. The prefix 0xFF, 0x00, 0x01 followed by a code byte clears nothing.
- R4: The pulse is active from the cycle in which the count equals the begin offset.
- R5: When end > begin, the pulse is active for counts in [begin, end) and inactive for all other counts.
- R6: When end <= begin, the pulse is active for count >= begin or count < end, so it stays active across the counter clear. When end equals begin, it is active on every count.
- R7: With the polarity bit at 1 the output is high while the pulse is active. With the polarity bit at 0 the output is low while the pulse is active.
- R8: The registers are laid out as follows. Address 0 holds the begin offset's upper 3 bits in data[6:4] and the end offset's upper 3 bits in data[2:0]. Address 1 holds the begin offset's lower 8 bits. Address 2 holds the end offset's lower 8 bits. Address 3 holds the polarity in bit 0.
- R9: A write takes effect at the first counter clear that follows it. A write made on the same edge as a clear waits for the next clear.
- R10: After reset, and until the first clear, the pulse stays inactive.
- R11: The reset values are begin 2, end 0 and polarity 0 (active low).
- R12: The counter rises by one per clock and holds at 4095 when no clear arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Line-locked clock, one byte per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| vid_byte | input | 8 | Multiplexed 4:2:2 stream byte |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | 8 | Register write data |
| hs_o | output | 1 | Horizontal sync output |

## Verification
The stream is driven with whole lines at 1716, 1560 and 1728 clocks, and these lines carry 1440, 1280 and 1440 active samples. Each line is framed by real end-of-active-video and start-of-active-video codes. Together they show that the pulse follows the code-defined counter rather than a fixed line length.

Some lines are deliberately damaged:
- A line whose end code has bit 4 cleared shows whether the start code and the end code are told apart.
- A line with a broken prefix shows whether the prefix is matched exactly.
- A long run with no codes at all shows whether the counter saturates or wraps.

Offsets are applied in several patterns: the defaults, hand-picked normal windows, windows where end is below begin, begin equal to end, and random values, each under both polarities. Writes land partway through a line, so the delay until the next counter clear is observed on every clock.

// File: rtl/hsg_pkg.sv
package hsg_pkg;
    localparam int DATA_W = 8;
    localparam int OFS_W  = 11;
    localparam int HI_W   = OFS_W - DATA_W;
    localparam int H_BIT  = 4;

    typedef struct packed {
        logic [OFS_W-1:0] beg;
        logic [OFS_W-1:0] fin;
        logic             pol_hi;
    } hs_cfg_t;

    localparam hs_cfg_t CFG_RST = '{beg: OFS_W'(2), fin: OFS_W'(0), pol_hi: 1'b0};

    typedef enum logic [1:0] {S_IDLE, S_FF, S_Z1, S_Z2} trs_state_e;
    typedef enum logic {T_UNLOCKED, T_RUN} tmr_state_e;
endpackage

// File: rtl/hsg_trs_detect.sv
module hsg_trs_detect
    import hsg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] byte_i,
    output logic              eav_o
);
    localparam logic [DATA_W-1:0] ONES  = {DATA_W{1'b1}};
    localparam logic [DATA_W-1:0] ZEROS = {DATA_W{1'b0}};

    trs_state_e state_q, state_d;

    always_comb begin
        state_d = S_IDLE;
        if (byte_i == ONES) begin
            state_d = S_FF;
        end else begin
            unique case (state_q)
                S_IDLE: state_d = S_IDLE;
                S_FF:   state_d = (byte_i == ZEROS) ? S_Z1 : S_IDLE;
                S_Z1:   state_d = (byte_i == ZEROS) ? S_Z2 : S_IDLE;
                S_Z2:   state_d = S_IDLE;
                default: state_d = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        eav_o = 1'b0;
        unique case (state_q)
            S_Z2:    eav_o = byte_i[H_BIT];
            default: eav_o = 1'b0;
        endcase
    end

    // R3
    prefix_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_Z2) |-> ($past(byte_i) == ZEROS));

    // R3
    prefix_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_FF) |-> ($past(byte_i) == ONES));
endmodule

// File: rtl/hsg_regs.sv
module hsg_regs
    import hsg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [1:0]        addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              eav_i,
    output hs_cfg_t           nxt_o,
    output hs_cfg_t           cur_o
);
    localparam logic [1:0] A_HI   = 2'd0;
    localparam logic [1:0] A_BEG  = 2'd1;
    localparam logic [1:0] A_FIN  = 2'd2;
    localparam logic [1:0] A_CTRL = 2'd3;

    hs_cfg_t stg_q, cur_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_q <= CFG_RST;
        end else if (we_i) begin
            unique case (addr_i)
                A_HI: begin
                    stg_q.beg[OFS_W-1:DATA_W] <= wdata_i[4 +: HI_W];
                    stg_q.fin[OFS_W-1:DATA_W] <= wdata_i[0 +: HI_W];
                end
                A_BEG:  stg_q.beg[DATA_W-1:0] <= wdata_i;
                A_FIN:  stg_q.fin[DATA_W-1:0] <= wdata_i;
                A_CTRL: stg_q.pol_hi          <= wdata_i[0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     cur_q <= CFG_RST;
        else if (eav_i) cur_q <= stg_q;
    end

    assign nxt_o = eav_i ? stg_q : cur_q;
    assign cur_o = cur_q;

    // R9
    shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !eav_i |=> $stable(cur_q));
endmodule

// File: rtl/hsg_timer.sv
module hsg_timer
    import hsg_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    eav_i,
    input  hs_cfg_t nxt_i,
    output logic    act_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    tmr_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             act_q, act_d;

    function automatic logic in_win(logic [CNT_W-1:0] c, logic [OFS_W-1:0] b,
                                    logic [OFS_W-1:0] e);
        logic [CNT_W-1:0] bw, ew;
        bw = CNT_W'(b);
        ew = CNT_W'(e);
        if (ew > bw) return (c >= bw) && (c < ew);
        else         return (c >= bw) || (c < ew);
    endfunction

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            T_UNLOCKED: if (eav_i) state_d = T_RUN;
            T_RUN:      state_d = T_RUN;
            default:    state_d = T_UNLOCKED;
        endcase
    end

    always_comb begin
        cnt_d = cnt_q;
        if (eav_i)                                   cnt_d = '0;
        else if (state_q == T_RUN && cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
        act_d = (state_d == T_RUN) && in_win(cnt_d, nxt_i.beg, nxt_i.fin);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= T_UNLOCKED;
            cnt_q   <= '0;
            act_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            act_q   <= act_d;
        end
    end

    assign act_o = act_q;

    // R1
    cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eav_i |=> (cnt_q == '0) && (state_q == T_RUN));

    // R12
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == T_RUN && !eav_i && cnt_q != CNT_MAX) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

    // R12
    cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_MAX && !eav_i) |=> (cnt_q == CNT_MAX));

    // R10
    unlocked_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == T_UNLOCKED) |-> !act_q);
endmodule

// File: rtl/hsync_gen.sv
module hsync_gen
    import hsg_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] vid_byte,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic              hs_o
);
    logic    eav;
    logic    act;
    hs_cfg_t cfg_nxt, cfg_cur;

    hsg_trs_detect u_det (
        .clk    (clk),
        .rst_n  (rst_n),
        .byte_i (vid_byte),
        .eav_o  (eav)
    );

    hsg_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (cfg_we),
        .addr_i  (cfg_addr),
        .wdata_i (cfg_wdata),
        .eav_i   (eav),
        .nxt_o   (cfg_nxt),
        .cur_o   (cfg_cur)
    );

    hsg_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .eav_i (eav),
        .nxt_i (cfg_nxt),
        .act_o (act)
    );

    assign hs_o = act ? cfg_cur.pol_hi : ~cfg_cur.pol_hi;

    // R7
    pol_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !act |-> (hs_o != cfg_cur.pol_hi));
endmodule

// File: tb/hsync_gen_tb.sv
module hsync_gen_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] vid_byte = 8'h10;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_addr = 2'd0;
    logic [7:0] cfg_wdata = 8'h00;
    logic       hs_o;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    string tag = "R11";

    always #5 clk = ~clk;

    hsync_gen u_dut (
        .clk(clk), .rst_n(rst_n), .vid_byte(vid_byte), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .hs_o(hs_o)
    );

    // behavioural reference
    int   m_cnt;
    bit   m_locked;
    int   s_beg, s_fin, c_beg, c_fin;
    bit   s_pol, c_pol, m_act;
    logic [7:0] hist[$];

    function automatic bit win(int c, int b, int e);
        if (e > b) return c >= b && c < e;
        return c >= b || c < e;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_locked = 0; m_act = 0;
            s_beg = 2; s_fin = 0; s_pol = 0;
            c_beg = 2; c_fin = 0; c_pol = 0;
            hist = '{8'h10, 8'h10, 8'h10};
        end else begin
            if (hist[0] == 8'hFF && hist[1] == 8'h00 && hist[2] == 8'h00 && vid_byte[4]) begin
                m_cnt = 0; m_locked = 1;
                c_beg = s_beg; c_fin = s_fin; c_pol = s_pol;
            end else if (m_locked && m_cnt < 4095) begin
                m_cnt++;
            end
            if (cfg_we) begin
                case (cfg_addr)
                    2'd0: begin
                        s_beg = (s_beg % 256) + 256 * ((cfg_wdata >> 4) % 8);
                        s_fin = (s_fin % 256) + 256 * (cfg_wdata % 8);
                    end
                    2'd1: s_beg = (s_beg / 256) * 256 + cfg_wdata;
                    2'd2: s_fin = (s_fin / 256) * 256 + cfg_wdata;
                    default: s_pol = cfg_wdata[0];
                endcase
            end
            void'(hist.pop_front());
            hist.push_back(vid_byte);
            m_act = m_locked && win(m_cnt, c_beg, c_fin);
        end
    end

    always @(negedge clk) begin
        logic exp_hs;
        cycles++;
        exp_hs = m_act ? c_pol : !c_pol;
        checks++;
        if (hs_o !== exp_hs) begin
            errors++;
            $display("FAIL %s cycle %0d: hs_o=%b expected %b (cnt=%0d)", tag, cycles, hs_o, exp_hs, m_cnt);
        end
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: cycles=%0d expected below 150000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic put(input logic [7:0] b);
        @(negedge clk);
        vid_byte = b;
    endtask

    // R8: register write through the byte port
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        vid_byte = 8'h80;
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_cfg(input int b, input int e, input bit p);
        wr(2'd0, 8'((((b / 256) % 8) << 4) | ((e / 256) % 8)));
        wr(2'd1, 8'(b % 256));
        wr(2'd2, 8'(e % 256));
        wr(2'd3, {7'd0, p});
    endtask

    task automatic line(input int total, input int act, input logic [7:0] xy, input logic [7:0] p2);
        put(8'hFF); put(8'h00); put(p2); put(xy);
        for (int i = 0; i < total - act - 8; i++) put(i[0] ? 8'h10 : 8'h80);
        put(8'hFF); put(8'h00); put(8'h00); put(8'hAB);
        for (int i = 0; i < act; i++) put(8'(8'h40 + (i % 64)));
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        tag = "R10";
        for (int i = 0; i < 30; i++) put(8'h80);
        tag = "R11";
        line(1716, 1440, 8'hB6, 8'h00);
        line(1716, 1440, 8'hB6, 8'h00);
        tag = "R1";
        line(1560, 1280, 8'hF1, 8'h00);
        tag = "R2";
        line(1728, 1440, 8'hA6, 8'h00);
        tag = "R3";
        line(1716, 1440, 8'hB6, 8'h01);
        line(1716, 1440, 8'hB6, 8'h00);
        tag = "R9";
        set_cfg(20, 200, 1);
        line(1716, 1440, 8'hB6, 8'h00);
        tag = "R5";
        line(1560, 1280, 8'hB6, 8'h00);
        tag = "R6";
        set_cfg(1500, 100, 0);
        line(1728, 1440, 8'hB6, 8'h00);
        line(1728, 1440, 8'hB6, 8'h00);
        set_cfg(300, 300, 1);
        line(1716, 1440, 8'hB6, 8'h00);
        line(1716, 1440, 8'hB6, 8'h00);
        tag = "R7";
        set_cfg(272, 400, 0);
        line(1716, 1440, 8'hB6, 8'h00);
        line(1716, 1440, 8'hB6, 8'h00);
        tag = "R4";
        for (int k = 0; k < 9; k++) begin
            int tot, act;
            tot = (k % 3 == 0) ? 1716 : (k % 3 == 1) ? 1560 : 1728;
            act = (k % 3 == 1) ? 1280 : 1440;
            set_cfg($urandom_range(0, 2047), $urandom_range(0, 2047), k[0]);
            line(tot, act, 8'hB6, 8'h00);
            line(tot, act, 8'hB6, 8'h00);
        end
        tag = "R8";
        set_cfg(1800, 1900, 1);
        line(1728, 1440, 8'hB6, 8'h00);
        tag = "R12";
        set_cfg(100, 2000, 1);
        line(1716, 1440, 8'hB6, 8'h00);
        for (int i = 0; i < 4400; i++) put(8'h80);
        line(1716, 1440, 8'hB6, 8'h00);
        @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule